// File: doc/BRIEF.md
# External trigger input conditioner

This block takes a raw external trigger pin and turns it into a clean, glitch-free level fit to serve as a trigger or as a counting clock. The pin is first brought into the kernel clock domain through a short synchronizer. An optional inversion then sets which level and edge count as active. An edge prescaler passes one active edge in 1, 2, 4 or 8. A digital glitch filter comes last: a 4-bit setting picks both how often the signal is sampled and how many agreeing samples in a row are needed before the output moves.

When the external-clock enable is set, every rising edge of the filtered level yields a one-kernel-cycle count-enable pulse that a counter elsewhere can use. The sampling base for the slower filter settings is a clock-enable strobe, `dts_tick_i`, supplied from outside. All configuration pins are plain levels and may be held static. No data stream crosses the block edge, so there is no valid/ready handshake and no back-pressure.

Top module: `etr_conditioner`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after release, `filt_level_o` and `edge_pulse_o` are 0.
- R2: With filter codes 1, 2 and 3, a pin change held steady reaches `filt_level_o` exactly 3+N kernel clock edges after the edge following the change (two synchronizer flops, one prescaler stage, N samples).
- R3: With `cfg_invert_i`=0 the pin is used as is; with `cfg_invert_i`=1 it is inverted, so a low pin gives a high filtered level and a falling pin edge gives the count pulse.
- R4: `cfg_psc_i` codes 0, 1, 2, 3 pass one of every 1, 2, 4, 8 rising edges of the conditioned signal; from reset, 16 input edges give 16, 8, 4, 2 count pulses.
- R5: Filter code 0 has N=1 and samples only on cycles where `dts_tick_i` is 1; with no tick the filtered level never changes.
- R6: Filter codes 1, 2, 3 sample every kernel cycle and need N of 2, 4, 8; a shorter run of the new level is rejected, a run of exactly N is accepted.
- R7: Filter codes 4 to 9 sample on every 2nd, 4th, 8th tick (codes 4-5, 6-7, 8-9); even codes need N=6, odd codes N=8.
- R8: Filter codes 10-12 sample on every 16th tick and codes 13-15 on every 32nd tick, needing N of 5, 6, 8 respectively.
- R9: With `cfg_extclk_en_i`=1, `edge_pulse_o` is high for exactly one kernel cycle, the cycle in which `filt_level_o` has just risen.
- R10: With `cfg_extclk_en_i`=0, `edge_pulse_o` stays 0.
- R11: Any sample that matches the present filtered level restarts the run count, and the filtered level only ever takes a value that the filter input held on the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Kernel clock |
| rst_ni | input | 1 | Active-low reset, synchronous release |
| dts_tick_i | input | 1 | Sampling-base strobe for filter codes 0 and 4-15 |
| pin_i | input | 1 | Raw external trigger pin, asynchronous |
| cfg_invert_i | input | 1 | 1 inverts the pin |
| cfg_psc_i | input | 2 | Edge prescaler code, divide by 2^code |
| cfg_filt_i | input | 4 | Filter setting: sampling rate and run length |
| cfg_extclk_en_i | input | 1 | Enables the count pulse |
| filt_level_o | output | 1 | Filtered, prescaled, polarity-corrected level |
| edge_pulse_o | output | 1 | One-cycle pulse on each rising edge of the filtered level |

## Verification
Single pin steps under kernel-rate filter codes pin down the exact latency of each stage, and pulses one cycle shorter than N versus exactly N tell the run length of each code apart. For the tick-divided codes, pulse widths chosen to fall just under and clearly over N sampling periods distinguish both the divisor and N, and a held-low tick shows that code 0 really waits for the strobe. Trains of 16 pin pulses under each prescaler code separate the four division ratios, while the inverted-polarity run and the enable-off run separate which edge and whether any edge makes a count pulse.

// File: rtl/etr_pkg.sv
package etr_pkg;
  localparam int unsigned FILT_W = 4;
  localparam int unsigned RUN_W  = 4;
  localparam int unsigned DIV_W  = 5;

  // Number of agreeing samples needed per filter setting.
  function automatic logic [RUN_W-1:0] run_len(input logic [FILT_W-1:0] code);
    case (code)
      4'd0:                 run_len = 4'd1;
      4'd1:                 run_len = 4'd2;
      4'd2:                 run_len = 4'd4;
      4'd3:                 run_len = 4'd8;
      4'd4, 4'd6, 4'd8:     run_len = 4'd6;
      4'd10, 4'd13:         run_len = 4'd5;
      4'd11, 4'd14:         run_len = 4'd6;
      default:              run_len = 4'd8;
    endcase
  endfunction

  // log2 of the tick divisor; only meaningful for tick-based codes.
  function automatic logic [2:0] div_log2(input logic [FILT_W-1:0] code);
    case (code)
      4'd4, 4'd5:           div_log2 = 3'd1;
      4'd6, 4'd7:           div_log2 = 3'd2;
      4'd8, 4'd9:           div_log2 = 3'd3;
      4'd10, 4'd11, 4'd12:  div_log2 = 3'd4;
      4'd13, 4'd14, 4'd15:  div_log2 = 3'd5;
      default:              div_log2 = 3'd0;
    endcase
  endfunction

  function automatic logic kernel_rate(input logic [FILT_W-1:0] code);
    kernel_rate = (code >= 4'd1) && (code <= 4'd3);
  endfunction
endpackage

// File: rtl/etr_sync.sv
module etr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[0] <= 1'b0;
          else         chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[g] <= 1'b0;
          else         chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/etr_prescaler.sv
module etr_prescaler #(
  parameter int unsigned PSC_W = 2,
  localparam int unsigned CNT_W = (1 << PSC_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             d_i,
  input  logic [PSC_W-1:0] psc_i,
  output logic             q_o
);
  logic             prev_q;
  logic [CNT_W-1:0] edges_q;
  logic             rise;

  assign rise = d_i && !prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      edges_q <= '0;
    end else begin
      prev_q <= d_i;
      if (rise) edges_q <= edges_q + 1'b1;
    end
  end

  // Bit k-1 of the edge counter rises once per 2^k input rising edges.
  always_comb begin
    if (psc_i == '0) q_o = prev_q;
    else             q_o = edges_q[psc_i - 1'b1];
  end
endmodule

// File: rtl/etr_filter.sv
module etr_filter
  import etr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              d_i,
  input  logic [FILT_W-1:0] code_i,
  output logic              q_o
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_mask;
  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] need;
  logic [RUN_W-1:0] run_next;
  logic             sample_en;
  logic             level_q;

  assign need     = run_len(code_i);
  assign div_mask = DIV_W'((1 << div_log2(code_i)) - 1);
  assign run_next = run_q + 1'b1;

  always_comb begin
    if (kernel_rate(code_i)) sample_en = 1'b1;
    else                     sample_en = tick_i && ((div_q & div_mask) == div_mask);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else if (tick_i) div_q <= div_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= '0;
      level_q <= 1'b0;
    end else if (sample_en) begin
      if (d_i != level_q) begin
        if (run_next >= need) begin
          level_q <= d_i;
          run_q   <= '0;
        end else begin
          run_q <= run_next;
        end
      end else begin
        run_q <= '0;
      end
    end
  end

  assign q_o = level_q;
endmodule

// File: rtl/etr_conditioner.sv
module etr_conditioner
  import etr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PSC_W       = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dts_tick_i,
  input  logic              pin_i,
  input  logic              cfg_invert_i,
  input  logic [PSC_W-1:0]  cfg_psc_i,
  input  logic [FILT_W-1:0] cfg_filt_i,
  input  logic              cfg_extclk_en_i,
  output logic              filt_level_o,
  output logic              edge_pulse_o
);
  logic pin_sync;
  logic pin_pol;
  logic presc_q;
  logic filt_q;
  logic filt_d_q;

  etr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  assign pin_pol = pin_sync ^ cfg_invert_i;

  etr_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_pol),
    .psc_i (cfg_psc_i),
    .q_o   (presc_q)
  );

  etr_filter u_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(dts_tick_i),
    .d_i   (presc_q),
    .code_i(cfg_filt_i),
    .q_o   (filt_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) filt_d_q <= 1'b0;
    else         filt_d_q <= filt_q;
  end

  assign filt_level_o = filt_q;
  assign edge_pulse_o = cfg_extclk_en_i && filt_q && !filt_d_q;
endmodule

// File: rtl/etr_conditioner_checker.sv
module etr_conditioner_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       dts_tick_i,
  input logic [3:0] cfg_filt_i,
  input logic       cfg_extclk_en_i,
  input logic       presc_q,
  input logic       filt_level_o,
  input logic       edge_pulse_o
);
  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_pulse_o |=> !edge_pulse_o); // R9

  AST_PULSE_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_pulse_o |-> (filt_level_o && !$past(filt_level_o))); // R9

  AST_PULSE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_extclk_en_i |-> !edge_pulse_o); // R10

  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_filt_i == 4'd0 && !dts_tick_i) |=> $stable(filt_level_o)); // R5

  AST_LEVEL_FROM_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_level_o != $past(filt_level_o)) |-> (filt_level_o == $past(presc_q))); // R11
endmodule

bind etr_conditioner etr_conditioner_checker u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .dts_tick_i     (dts_tick_i),
  .cfg_filt_i     (cfg_filt_i),
  .cfg_extclk_en_i(cfg_extclk_en_i),
  .presc_q        (presc_q),
  .filt_level_o   (filt_level_o),
  .edge_pulse_o   (edge_pulse_o)
);

// File: tb/test_etr_conditioner.sv
`timescale 1ns/1ps
module test_etr_conditioner;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       pin = 1'b0;
  logic       inv = 1'b0;
  logic [1:0] psc = 2'd0;
  logic [3:0] filt = 4'd1;
  logic       ext = 1'b1;
  logic       lvl;
  logic       pulse;

  int n_checks = 0;
  int n_fail   = 0;
  int pulses   = 0;
  bit seen_hi  = 1'b0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  etr_conditioner i_etr_conditioner (
    .clk_i(clk), .rst_ni(rst_n), .dts_tick_i(tick), .pin_i(pin),
    .cfg_invert_i(inv), .cfg_psc_i(psc), .cfg_filt_i(filt),
    .cfg_extclk_en_i(ext), .filt_level_o(lvl), .edge_pulse_o(pulse)
  );

  always @(negedge clk) begin
    if (pulse) pulses++;
    if (lvl) seen_hi = 1'b1;
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset(input logic i_inv, input logic [1:0] i_psc,
                          input logic [3:0] i_filt, input logic i_ext);
    @(negedge clk);
    rst_n = 1'b0; pin = 1'b0; inv = i_inv; psc = i_psc; filt = i_filt; ext = i_ext; tick = 1'b1;
    cycles(3);
    rst_n = 1'b1;
    pulses = 0; seen_hi = 1'b0;
  endtask

  task automatic clear_obs();
    pulses = 0; seen_hi = 1'b0;
  endtask

  // Drive a high pulse of len cycles, then low for tail cycles.
  task automatic pin_pulse(input int len, input int tail);
    pin = 1'b1; cycles(len);
    pin = 1'b0; cycles(tail);
  endtask

  task automatic t_reset();
    @(negedge clk); rst_n = 1'b0; cycles(2);
    check("R1 level in reset", lvl, 0);
    check("R1 pulse in reset", pulse, 0);
    rst_n = 1'b1; cycles(1);
    check("R1 level after release", lvl, 0);
    check("R1 pulse after release", pulse, 0);
  endtask

  // Exact latency 3+N and single-cycle pulse for kernel-rate codes.
  task automatic t_latency(input logic [3:0] code, input int n);
    do_reset(1'b0, 2'd0, code, 1'b1);
    cycles(2);
    pin = 1'b1;
    cycles(3 + n - 1);
    check($sformatf("R2 code %0d level before 3+N", code), lvl, 0);
    cycles(1);
    check($sformatf("R2 code %0d level at 3+N", code), lvl, 1);
    check($sformatf("R9 code %0d pulse in rise cycle", code), pulse, 1);
    cycles(1);
    check($sformatf("R9 code %0d pulse gone next cycle", code), pulse, 0);
    check($sformatf("R9 code %0d pulse count", code), pulses, 1);
  endtask

  task automatic t_runlen(input logic [3:0] code, input int n);
    do_reset(1'b0, 2'd0, code, 1'b1);
    cycles(2);
    pin_pulse(n - 1, 20);
    check($sformatf("R6 code %0d run N-1 rejected", code), seen_hi, 0);
    clear_obs();
    pin_pulse(n, 20);
    check($sformatf("R6 code %0d run N accepted", code), seen_hi, 1);
  endtask

  task automatic t_restart();
    // code 3 (N=8): 5 high, 1 low, 5 high must not pass since the low sample restarts the run
    do_reset(1'b0, 2'd0, 4'd3, 1'b1);
    cycles(2);
    pin = 1'b1; cycles(5); pin = 1'b0; cycles(1); pin = 1'b1; cycles(5); pin = 1'b0;
    cycles(20);
    check("R11 broken run restarts count", seen_hi, 0);
  endtask

  task automatic t_divided(input logic [3:0] code, input int short_len,
                           input int long_len, input string req);
    do_reset(1'b0, 2'd0, code, 1'b1);
    cycles(2);
    pin_pulse(short_len, 300);
    check($sformatf("%s code %0d short pulse rejected", req, code), seen_hi, 0);
    clear_obs();
    pin_pulse(long_len, 300);
    check($sformatf("%s code %0d long pulse accepted", req, code), seen_hi, 1);
  endtask

  task automatic t_code0();
    do_reset(1'b0, 2'd0, 4'd0, 1'b1);
    tick = 1'b0;
    cycles(2);
    pin = 1'b1; cycles(20);
    check("R5 no tick holds level", lvl, 0);
    pin = 1'b0; cycles(10);
    do_reset(1'b0, 2'd0, 4'd0, 1'b1);
    cycles(2);
    pin = 1'b1;
    cycles(3);
    check("R5 code 0 level before 4 edges", lvl, 0);
    cycles(1);
    check("R5 code 0 level after 4 edges with tick", lvl, 1);
  endtask

  task automatic t_prescaler(input logic [1:0] code, input int exp);
    do_reset(1'b0, code, 4'd1, 1'b1);
    cycles(2);
    for (int k = 0; k < 16; k++) pin_pulse(4, 4);
    cycles(20);
    check($sformatf("R4 prescaler code %0d pulses from 16 edges", code), pulses, exp);
  endtask

  task automatic t_polarity();
    do_reset(1'b1, 2'd0, 4'd1, 1'b1);
    cycles(10);
    check("R3 inverted low pin gives high level", lvl, 1);
    pin = 1'b1; cycles(10);
    check("R3 inverted high pin gives low level", lvl, 0);
    clear_obs();
    pin = 1'b0; cycles(10);
    check("R3 falling pin edge gives one pulse", pulses, 1);
  endtask

  task automatic t_disabled();
    do_reset(1'b0, 2'd0, 4'd1, 1'b0);
    cycles(2);
    for (int k = 0; k < 4; k++) pin_pulse(6, 6);
    check("R10 level still toggles", seen_hi, 1);
    check("R10 no pulse while disabled", pulses, 0);
  endtask

  initial begin
    t_reset();
    t_latency(4'd1, 2);
    t_latency(4'd2, 4);
    t_latency(4'd3, 8);
    t_runlen(4'd1, 2);
    t_runlen(4'd2, 4);
    t_runlen(4'd3, 8);
    t_restart();
    t_code0();
    t_divided(4'd4, 10, 14, "R7");   // tick/2, N=6
    t_divided(4'd5, 14, 18, "R7");   // tick/2, N=8
    t_divided(4'd7, 28, 36, "R7");   // tick/4, N=8
    t_divided(4'd12, 112, 150, "R8"); // tick/16, N=8
    t_divided(4'd13, 120, 200, "R8"); // tick/32, N=5
    t_prescaler(2'd0, 16);
    t_prescaler(2'd1, 8);
    t_prescaler(2'd2, 4);
    t_prescaler(2'd3, 2);
    t_polarity();
    t_disabled();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule